// File: doc/BRIEF.md
# Byte-Lane Data Memory Interface

This block connects the memory stage of a 32-bit pipeline to a data RAM that is 32 bits wide, byte addressed, and built as four parallel 8-bit banks. Each bank has its own write enable. On every request the block adds the base register to the sign-extended 16-bit offset. It then decodes the load or store opcode and uses the two low address bits to choose the byte lanes.

For a store, the block copies the store data across all lanes and raises only the write enables of the addressed byte, halfword or word. The other bytes of the word keep their contents. For a load, the RAM is synchronous, so the read word arrives one cycle later. The block keeps the lane offset, size and sign mode of the load in registers. When the word arrives, it picks out the addressed byte or halfword and extends it with zeros or with the sign bit. A misaligned halfword or word access raises an error flag and does not touch the RAM.

Top module: `bytelane_dmem_if`

## Requirements
- R1: The effective address is `base` plus the 16-bit `offset` sign-extended. `ram_addr` is that address without its two low bits.
- R2: A word store (opcode 101011) at an offset of 0 raises all four write enables and drives `st_data` unchanged on `ram_wdata`.
- R3: A halfword store (opcode 101001) writes the low 16 bits of `st_data` to both halves of `ram_wdata`. It enables lanes 1:0 (`ram_we`=0011) at offset 0 and lanes 3:2 (`ram_we`=1100) at offset 2.
- R4: A byte store (opcode 101000) copies `st_data[7:0]` to all four lanes. It enables only lane N, where N is the offset (0 to 3). Lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R5: A word load (opcode 100011) sets `ram_en` with no write enables. In the next cycle `ld_valid` is high and `ld_data` holds the whole stored word.
- R6: Signed byte loads (100000) and signed halfword loads (100001) return the addressed lane, extended with its top bit. A halfword at offset 2 comes from bits 31:16.
- R7: Unsigned byte loads (100100) and unsigned halfword loads (100101) return the addressed lane, extended with zeros.
- R8: A halfword access at an odd address, or a word access whose two low bits are not 00, raises `align_err` in the same cycle. `ram_en` and `ram_we` stay low, and no `ld_valid` follows.
- R9: When `req_valid` is low, or the opcode is none of the eight above, `ram_en`, `ram_we` and `align_err` stay low and no `ld_valid` follows.
- R10: While `rst_n` is low, `ld_valid` is low.
- R11: After a partial store, a word load shows the written bytes updated and every other byte of the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A memory request is present this cycle |
| opcode | input | 6 | Load or store opcode |
| base | input | ADDR_W | Base register value |
| offset | input | OFF_W | Signed immediate offset |
| st_data | input | DATA_W | Store data, right-justified |
| ram_addr | output | ADDR_W-2 | Word address to the banks |
| ram_en | output | 1 | Bank access strobe |
| ram_we | output | DATA_W/8 | Write enable for each byte lane |
| ram_wdata | output | DATA_W | Store data copied across the lanes |
| ram_rdata | input | DATA_W | Word read from the banks one cycle after `ram_en` |
| ld_data | output | DATA_W | Aligned and extended load result |
| ld_valid | output | 1 | `ld_data` is valid this cycle |
| align_err | output | 1 | The current request is misaligned |

## Verification
The load return and the next request's store lanes can both be active in one cycle. The bench provokes this by issuing a word load and, in the very next cycle, a word store to the same address. In that cycle it checks that `ld_valid` shows the old contents while all four enables are driven for the new word. A later load must then return the new word. The bench also returns a load in the same cycle as a misaligned store, and checks that the error flag does not disturb the returning data.

// File: rtl/bytelane_dmem_pkg.sv
package bytelane_dmem_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      is_ld;
    logic      is_st;
    acc_size_e size;
    logic      sext;
  } acc_ctl_t;

  localparam logic [5:0] OPC_LB  = 6'b100000;
  localparam logic [5:0] OPC_LH  = 6'b100001;
  localparam logic [5:0] OPC_LW  = 6'b100011;
  localparam logic [5:0] OPC_LBU = 6'b100100;
  localparam logic [5:0] OPC_LHU = 6'b100101;
  localparam logic [5:0] OPC_SB  = 6'b101000;
  localparam logic [5:0] OPC_SH  = 6'b101001;
  localparam logic [5:0] OPC_SW  = 6'b101011;

endpackage

// File: rtl/bytelane_dmem_decode.sv
module bytelane_dmem_decode
  import bytelane_dmem_pkg::*;
(
  input  logic [5:0] opcode,
  output acc_ctl_t   ctl
);

  always_comb begin
    ctl = '{is_ld: 1'b0, is_st: 1'b0, size: SZ_BYTE, sext: 1'b0};
    unique case (opcode)
      OPC_LB:  ctl = '{is_ld: 1'b1, is_st: 1'b0, size: SZ_BYTE, sext: 1'b1};
      OPC_LBU: ctl = '{is_ld: 1'b1, is_st: 1'b0, size: SZ_BYTE, sext: 1'b0};
      OPC_LH:  ctl = '{is_ld: 1'b1, is_st: 1'b0, size: SZ_HALF, sext: 1'b1};
      OPC_LHU: ctl = '{is_ld: 1'b1, is_st: 1'b0, size: SZ_HALF, sext: 1'b0};
      OPC_LW:  ctl = '{is_ld: 1'b1, is_st: 1'b0, size: SZ_WORD, sext: 1'b0};
      OPC_SB:  ctl = '{is_ld: 1'b0, is_st: 1'b1, size: SZ_BYTE, sext: 1'b0};
      OPC_SH:  ctl = '{is_ld: 1'b0, is_st: 1'b1, size: SZ_HALF, sext: 1'b0};
      OPC_SW:  ctl = '{is_ld: 1'b0, is_st: 1'b1, size: SZ_WORD, sext: 1'b0};
      default: ;
    endcase
  end

endmodule

// File: rtl/bytelane_dmem_lanes.sv
module bytelane_dmem_lanes
  import bytelane_dmem_pkg::*;
#(
  parameter int DATA_W  = 32,
  localparam int LANES   = DATA_W / 8,
  localparam int LANE_AW = $clog2(LANES),
  localparam int HALVES  = LANES / 2
) (
  input  logic               go,
  input  acc_ctl_t           ctl,
  input  logic [LANE_AW-1:0] lane_off,
  input  logic [DATA_W-1:0]  st_data,
  output logic               misal,
  output logic               rd_go,
  output logic               wr_go,
  output logic [LANES-1:0]   we,
  output logic [DATA_W-1:0]  wdata
);

  logic known;

  always_comb begin
    known = ctl.is_ld | ctl.is_st;
    misal = 1'b0;
    if (go && known) begin
      unique case (ctl.size)
        SZ_WORD: misal = (lane_off != '0);
        SZ_HALF: misal = lane_off[0];
        default: misal = 1'b0;
      endcase
    end
    rd_go = go & ctl.is_ld & ~misal;
    wr_go = go & ctl.is_st & ~misal;
  end

  always_comb begin
    unique case (ctl.size)
      SZ_WORD: wdata = st_data;
      SZ_HALF: wdata = {HALVES{st_data[15:0]}};
      default: wdata = {LANES{st_data[7:0]}};
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LANE_AW-1:0] IDX = LANE_AW'(i);
    logic hit;
    always_comb begin
      unique case (ctl.size)
        SZ_WORD: hit = 1'b1;
        SZ_HALF: hit = (IDX[LANE_AW-1:1] == lane_off[LANE_AW-1:1]);
        default: hit = (IDX == lane_off);
      endcase
      we[i] = wr_go & hit;
    end
  end

endmodule

// File: rtl/bytelane_dmem_extract.sv
module bytelane_dmem_extract
  import bytelane_dmem_pkg::*;
#(
  parameter int DATA_W  = 32,
  localparam int LANE_AW = $clog2(DATA_W / 8)
) (
  input  logic [DATA_W-1:0]  rdata,
  input  logic [LANE_AW-1:0] lane_off,
  input  acc_size_e          size,
  input  logic               sext,
  output logic [DATA_W-1:0]  value
);

  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    sel_b = rdata[{lane_off, 3'b000} +: 8];
    sel_h = rdata[{lane_off[LANE_AW-1:1], 4'b0000} +: 16];
    unique case (size)
      SZ_WORD: value = rdata;
      SZ_HALF: value = {{(DATA_W-16){sext & sel_h[15]}}, sel_h};
      default: value = {{(DATA_W-8){sext & sel_b[7]}}, sel_b};
    endcase
  end

endmodule

// File: rtl/bytelane_dmem_if.sv
module bytelane_dmem_if
  import bytelane_dmem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 32,
  localparam int LANES   = DATA_W / 8,
  localparam int LANE_AW = $clog2(LANES),
  localparam int WADDR_W = ADDR_W - LANE_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [5:0]         opcode,
  input  logic [ADDR_W-1:0]  base,
  input  logic [OFF_W-1:0]   offset,
  input  logic [DATA_W-1:0]  st_data,
  output logic [WADDR_W-1:0] ram_addr,
  output logic               ram_en,
  output logic [LANES-1:0]   ram_we,
  output logic [DATA_W-1:0]  ram_wdata,
  input  logic [DATA_W-1:0]  ram_rdata,
  output logic [DATA_W-1:0]  ld_data,
  output logic               ld_valid,
  output logic               align_err
);

  acc_ctl_t           ctl;
  logic [ADDR_W-1:0]  eff_addr;
  logic               rd_go;
  logic               wr_go;

  // load context held across the synchronous read
  logic               pend_q, pend_d;
  logic               cap_en;
  logic [LANE_AW-1:0] off_q, off_d;
  acc_size_e          size_q, size_d;
  logic               sext_q, sext_d;

  assign eff_addr = base + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};

  bytelane_dmem_decode u_dec (
    .opcode (opcode),
    .ctl    (ctl)
  );

  bytelane_dmem_lanes #(.DATA_W(DATA_W)) u_lanes (
    .go       (req_valid),
    .ctl      (ctl),
    .lane_off (eff_addr[LANE_AW-1:0]),
    .st_data  (st_data),
    .misal    (align_err),
    .rd_go    (rd_go),
    .wr_go    (wr_go),
    .we       (ram_we),
    .wdata    (ram_wdata)
  );

  assign ram_addr = eff_addr[ADDR_W-1:LANE_AW];
  assign ram_en   = rd_go | wr_go;

  always_comb begin
    pend_d = rd_go;
    cap_en = rd_go;
    off_d  = eff_addr[LANE_AW-1:0];
    size_d = ctl.size;
    sext_d = ctl.sext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      off_q  <= '0;
      size_q <= SZ_BYTE;
      sext_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (cap_en) begin
        off_q  <= off_d;
        size_q <= size_d;
        sext_q <= sext_d;
      end
    end
  end

  bytelane_dmem_extract #(.DATA_W(DATA_W)) u_ext (
    .rdata    (ram_rdata),
    .lane_off (off_q),
    .size     (size_q),
    .sext     (sext_q),
    .value    (ld_data)
  );

  assign ld_valid = pend_q;

endmodule

// File: rtl/bytelane_dmem_chk.sv
module bytelane_dmem_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             ram_en,
  input logic [LANES-1:0] ram_we,
  input logic             ld_valid,
  input logic             align_err
);

  // R8
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (ram_we == '0 && !ram_en));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (ram_we == '0 && !ram_en && !align_err));

  // R5
  load_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(ram_en && ram_we == '0));

  // R4
  lane_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we != '0) |-> (ram_en && $countones(ram_we) != 3));

  // R8
  misalign_no_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> !ld_valid);

endmodule

bind bytelane_dmem_if bytelane_dmem_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .ram_en    (ram_en),
  .ram_we    (ram_we),
  .ld_valid  (ld_valid),
  .align_err (align_err)
);

// File: tb/bytelane_dmem_if_tb_top.sv
`timescale 1ns/1ps
module bytelane_dmem_if_tb_top;

  localparam logic [5:0] LB = 6'b100000, LH = 6'b100001, LW = 6'b100011,
                         LBU = 6'b100100, LHU = 6'b100101,
                         SB = 6'b101000, SH = 6'b101001, SW = 6'b101011;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [5:0]  opcode;
  logic [31:0] base;
  logic [15:0] offset;
  logic [31:0] st_data;
  logic [29:0] ram_addr;
  logic        ram_en;
  logic [3:0]  ram_we;
  logic [31:0] ram_wdata;
  logic [31:0] ram_rdata;
  logic [31:0] ld_data;
  logic        ld_valid;
  logic        align_err;

  int nvec = 0;
  int nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bytelane_dmem_if dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
    .base(base), .offset(offset), .st_data(st_data), .ram_addr(ram_addr),
    .ram_en(ram_en), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .ld_data(ld_data), .ld_valid(ld_valid),
    .align_err(align_err)
  );

  // four byte banks, read-first, synchronous
  logic [7:0] bank [4][256];
  always @(posedge clk) begin
    if (ram_en) begin
      for (int i = 0; i < 4; i++)
        if (ram_we[i]) bank[i][ram_addr[7:0]] <= ram_wdata[i*8 +: 8];
      if (ram_we == 4'b0000)
        ram_rdata <= {bank[3][ram_addr[7:0]], bank[2][ram_addr[7:0]],
                      bank[1][ram_addr[7:0]], bank[0][ram_addr[7:0]]};
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [5:0] op, input logic [31:0] b,
                       input logic [15:0] o, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; opcode = op; base = b; offset = o; st_data = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; opcode = 6'd0; base = '0; offset = '0; st_data = '0;
    #1;
  endtask

  task automatic load_chk(input string tag, input logic [5:0] op,
                          input logic [31:0] addr, input logic [31:0] exp);
    drive(op, addr, 16'h0000, 32'h0);
    chk({tag, " en"}, {31'b0, ram_en}, 32'd1);
    idle();
    chk({tag, " valid"}, {31'b0, ld_valid}, 32'd1);
    chk({tag, " data"}, ld_data, exp);
  endtask

  task automatic t_reset();
    chk("R10 ld_valid in reset", {31'b0, ld_valid}, 32'd0);
    chk("R9 ram_en idle", {31'b0, ram_en}, 32'd0);
    chk("R9 ram_we idle", {28'b0, ram_we}, 32'd0);
    chk("R9 align_err idle", {31'b0, align_err}, 32'd0);
  endtask

  task automatic t_word();
    drive(SW, 32'h0000_0100, 16'hFFFC, 32'hDEAD_BEEF);
    chk("R1 addr", {2'b0, ram_addr}, 32'h3F);
    chk("R2 we", {28'b0, ram_we}, 32'hF);
    chk("R2 wdata", ram_wdata, 32'hDEAD_BEEF);
    idle();
    load_chk("R5 LW", LW, 32'h0000_00FC, 32'hDEAD_BEEF);
  endtask

  task automatic t_half_store();
    drive(SW, 32'h200, 16'h0, 32'h1122_3344); idle();
    drive(SH, 32'h200, 16'h0002, 32'h1234_ABCD);
    chk("R3 we hi", {28'b0, ram_we}, 32'hC);
    chk("R3 wdata", ram_wdata, 32'hABCD_ABCD);
    drive(SH, 32'h1FF, 16'h0001, 32'h0000_BEEF);
    chk("R1 R3 we lo", {28'b0, ram_we}, 32'h3);
    chk("R1 addr", {2'b0, ram_addr}, 32'h80);
    idle();
    load_chk("R11 half", LW, 32'h200, 32'hABCD_BEEF);
  endtask

  task automatic t_byte_store();
    drive(SW, 32'h300, 16'h0, 32'h0); idle();
    drive(SB, 32'h301, 16'h0, 32'hFFFF_FF5A);
    chk("R4 we lane1", {28'b0, ram_we}, 32'h2);
    chk("R4 wdata", ram_wdata, 32'h5A5A_5A5A);
    drive(SB, 32'h304, 16'hFFFF, 32'h0000_0080);
    chk("R4 we lane3", {28'b0, ram_we}, 32'h8);
    idle();
    load_chk("R11 byte", LW, 32'h300, 32'h8000_5A00);
  endtask

  task automatic t_signed();
    load_chk("R6 LB neg", LB, 32'h303, 32'hFFFF_FF80);
    load_chk("R6 LB pos", LB, 32'h301, 32'h0000_005A);
    load_chk("R6 LH hi", LH, 32'h302, 32'hFFFF_8000);
    load_chk("R6 LH lo", LH, 32'h200, 32'hFFFF_BEEF);
  endtask

  task automatic t_unsigned();
    load_chk("R7 LBU", LBU, 32'h303, 32'h0000_0080);
    load_chk("R7 LHU hi", LHU, 32'h202, 32'h0000_ABCD);
    load_chk("R7 LHU lo", LHU, 32'h200, 32'h0000_BEEF);
  endtask

  task automatic t_misalign();
    drive(SW, 32'h302, 16'h0, 32'hFFFF_FFFF);
    chk("R8 SW err", {31'b0, align_err}, 32'd1);
    chk("R8 SW we", {28'b0, ram_we}, 32'h0);
    drive(SH, 32'h301, 16'h0, 32'hFFFF_FFFF);
    chk("R8 SH err", {31'b0, align_err}, 32'd1);
    chk("R8 SH en", {31'b0, ram_en}, 32'd0);
    drive(LW, 32'h201, 16'h0, 32'h0);
    chk("R8 LW err", {31'b0, align_err}, 32'd1);
    idle();
    chk("R8 no ld_valid", {31'b0, ld_valid}, 32'd0);
    drive(LB, 32'h301, 16'h0, 32'h0);
    chk("R8 byte any offset ok", {31'b0, align_err}, 32'd0);
    idle();
    load_chk("R8 R11 untouched", LW, 32'h300, 32'h8000_5A00);
  endtask

  task automatic t_illegal();
    drive(6'b001111, 32'h300, 16'h0, 32'hFFFF_FFFF);
    chk("R9 bad op en", {31'b0, ram_en}, 32'd0);
    chk("R9 bad op err", {31'b0, align_err}, 32'd0);
    idle();
    chk("R9 bad op no valid", {31'b0, ld_valid}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0; opcode = SW; base = 32'h302; st_data = 32'hFFFF_FFFF;
    #1;
    chk("R9 no req we", {28'b0, ram_we}, 32'h0);
    chk("R9 no req err", {31'b0, align_err}, 32'd0);
    idle();
    load_chk("R9 untouched", LW, 32'h300, 32'h8000_5A00);
  endtask

  task automatic t_overlap();
    drive(LW, 32'h200, 16'h0, 32'h0);
    drive(SW, 32'h200, 16'h0, 32'hCAFE_F00D);
    chk("R5 overlap valid", {31'b0, ld_valid}, 32'd1);
    chk("R5 overlap old data", ld_data, 32'hABCD_BEEF);
    chk("R2 overlap we", {28'b0, ram_we}, 32'hF);
    idle();
    load_chk("R2 overlap new", LW, 32'h200, 32'hCAFE_F00D);
    drive(LHU, 32'h202, 16'h0, 32'h0);
    drive(SW, 32'h301, 16'h0, 32'h0);
    chk("R8 overlap err", {31'b0, align_err}, 32'd1);
    chk("R7 overlap data", ld_data, 32'h0000_CAFE);
    idle();
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; opcode = '0; base = '0; offset = '0; st_data = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_word();
    t_half_store();
    t_byte_store();
    t_signed();
    t_unsigned();
    t_misalign();
    t_illegal();
    t_overlap();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule